// File: doc/BRIEF.md
# Phase-Accumulator Multi-Channel PWM

This block turns a fast system clock into slow pulse-width modulated outputs with 8-bit duty resolution on several channels at once. A free-running prescaler emits a base tick once every 256 clocks. On each tick a 16-bit phase accumulator adds a programmable increment. The carry out of its top bit is the PWM step enable. Because the step rate comes from an accumulator carry, it need not be a whole division of the clock. Step edges fall only on base-tick boundaries, so their timing jitters by up to one tick interval.

All channels share one 8-bit position counter, which advances once per step and wraps after 256 steps. Each channel compares the position against its own active duty value. A new duty is taken from the input only when the position wraps, so a period is never cut short or stretched. The increment is chosen as 2^32 divided by the clock rate, rounded. For a 5 MHz clock this gives about 256 steps per second, which is a 1 Hz PWM period.

Top module: `pwm_phase_top`

## Requirements
- R1: The base tick fires once every 256 clocks. With an increment of 0xFFFF, consecutive steps after the first are exactly 256 clocks apart.
- R2: The 16-bit accumulator is cleared by reset and adds `delta_i` on every base tick, wrapping modulo 2^16. A step is taken only on a tick whose addition carries out of bit 15. With 0x035B, the first step falls on the 77th tick, at clock edge 19712 after reset release. With 0xFFFF, it falls on the 2nd tick, at edge 512.
- R3: `step_o` is high for exactly one clock, in the cycle after the edge that takes the step.
- R4: One 8-bit position counter, shared by all channels, advances by one per step and wraps from 255 to 0. After the m-th step since reset its value is m mod 256.
- R5: Channel k drives `pwm_o[k]` high while position < active duty. An active duty of 0 keeps the output low for the whole period.
- R6: An active duty of 255 drives the output low only at position 255.
- R7: Channel k's duty is read from `duty_i[8k+7:8k]` only on the step that wraps the position from 255 to 0. Changes to the input at any other time do not affect the output. Reset sets every active duty to 0, so all outputs stay low until the first wrap.
- R8: While `rst_ni` is low, `pwm_o` and `step_o` are 0, and the prescaler, accumulator and position are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| delta_i | input | 16 | Phase increment added on each base tick |
| duty_i | input | NUM_CH*8 | Per-channel duty values, channel k in bits [8k+7:8k] |
| pwm_o | output | NUM_CH | Per-channel PWM outputs |
| step_o | output | 1 | One-clock pulse per PWM step |

## Verification
The hardest condition to reach is the duty handover at the 255-to-0 wrap. It occurs only after 256 steps, and each step costs at least 256 clocks. The bench therefore uses an increment of 0xFFFF, so that a step falls on every tick after the first. It loads the duty inputs well before the first wrap and then confirms that outputs stay low through the first period. Just after the wrap it changes every duty to a contrasting value and walks positions up to 255 of the second period. The outputs must keep following the duties captured at the wrap. A separate run with 0x035B pins the first carry to the exact clock edge the accumulator arithmetic predicts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  parameter int unsigned DEF_TICK_W = 8;
  parameter int unsigned DEF_ACC_W  = 16;
  parameter int unsigned DEF_POS_W  = 8;
  parameter int unsigned DEF_NUM_CH = 4;
endpackage

// File: rtl/pwm_tick_gen.sv
module pwm_tick_gen #(
  parameter int unsigned TICK_W = pwm_pkg::DEF_TICK_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  logic [TICK_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + TICK_W'(1);
  end

  assign tick_o = &cnt_q;

  // ticks never come back to back
  assert_tick_spacing_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pwm_phase_acc.sv
module pwm_phase_acc #(
  parameter int unsigned ACC_W = pwm_pkg::DEF_ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [ACC_W-1:0] delta_i,
  output logic             step_o
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, delta_i};
  assign step_o = tick_i & sum[ACC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= sum[ACC_W-1:0];
  end

  assert_acc_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> acc_q == ACC_W'($past(acc_q) + $past(delta_i)));
  assert_acc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc_q));
endmodule

// File: rtl/pwm_pos_cnt.sv
module pwm_pos_cnt #(
  parameter int unsigned POS_W = pwm_pkg::DEF_POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [POS_W-1:0] pos_o,
  output logic             wrap_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (step_i) pos_q <= pos_q + POS_W'(1);
  end

  assign pos_o  = pos_q;
  assign wrap_o = step_i & (&pos_q);

  assert_pos_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> pos_q == POS_W'($past(pos_q) + POS_W'(1)));
  assert_pos_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pos_q));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned POS_W = pwm_pkg::DEF_POS_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] duty_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic             wrap_i,
  output logic             pwm_o
);
  logic [POS_W-1:0] duty_q;

  // shadow load only at period boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     duty_q <= '0;
    else if (wrap_i) duty_q <= duty_i;
  end

  assign pwm_o = pos_i < duty_q;

  assert_duty_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(duty_q));
  assert_zero_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_q == '0) |-> !pwm_o);
  assert_last_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pos_i) |-> !pwm_o);
endmodule

// File: rtl/pwm_phase_top.sv
module pwm_phase_top #(
  parameter int unsigned TICK_W = pwm_pkg::DEF_TICK_W,
  parameter int unsigned ACC_W  = pwm_pkg::DEF_ACC_W,
  parameter int unsigned POS_W  = pwm_pkg::DEF_POS_W,
  parameter int unsigned NUM_CH = pwm_pkg::DEF_NUM_CH
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ACC_W-1:0]        delta_i,
  input  logic [NUM_CH*POS_W-1:0] duty_i,
  output logic [NUM_CH-1:0]       pwm_o,
  output logic                    step_o
);
  logic             tick;
  logic             step;
  logic             wrap;
  logic [POS_W-1:0] pos;
  logic             step_q;

  pwm_tick_gen #(.TICK_W(TICK_W)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  pwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .delta_i(delta_i),
    .step_o (step)
  );

  pwm_pos_cnt #(.POS_W(POS_W)) u_pos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(step),
    .pos_o (pos),
    .wrap_o(wrap)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    pwm_chan #(.POS_W(POS_W)) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .duty_i(duty_i[k*POS_W +: POS_W]),
      .pos_i (pos),
      .wrap_i(wrap),
      .pwm_o (pwm_o[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= 1'b0;
    else         step_q <= step;
  end

  assign step_o = step_q;

  assert_step_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> tick);
  assert_step_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  always_comb begin
    if (rst_ni === 1'b0) begin
      assert_reset_quiet_R8: assert (pwm_o == '0 && step_o == 1'b0);
    end
  end
endmodule

// File: tb/tb_pwm_phase_top.sv
module tb_pwm_phase_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] delta_i = 16'h035B;
  logic [31:0] duty_i = '0;
  logic [3:0]  pwm_o;
  logic        step_o;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  int unsigned edges;
  bit          done = 1'b0;

  localparam logic [31:0] DUTY_A = {8'd255, 8'd128, 8'd1, 8'd0};
  localparam logic [31:0] DUTY_B = {8'd0, 8'd0, 8'd255, 8'd255};

  // step index since reset, expected outputs (ch3..ch0)
  localparam int       NV = 9;
  localparam int       VSTEP [NV] = '{5, 200, 256, 257, 300, 383, 384, 510, 511};
  localparam bit [3:0] VEXP  [NV] = '{4'b0000, 4'b0000, 4'b1110, 4'b1100, 4'b1100,
                                      4'b1100, 4'b1000, 4'b1000, 4'b0000};
  localparam string    VREQ  [NV] = '{"R7", "R7", "R5", "R4", "R7",
                                      "R7", "R5", "R4", "R6"};

  pwm_phase_top dut (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .delta_i(delta_i),
    .duty_i (duty_i),
    .pwm_o  (pwm_o),
    .step_o (step_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) edges <= 0;
    else         edges <= edges + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", req, act, exp, edges);
    end
  endtask

  task automatic find_step(input int unsigned limit, output int found);
    found = -1;
    while (found < 0 && edges < limit) begin
      @(negedge clk_i);
      if (step_o) found = int'(edges);
    end
  endtask

  task automatic wait_to(input int unsigned n);
    while (edges < n) @(negedge clk_i);
  endtask

  task automatic do_reset;
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R8 pwm", {28'd0, pwm_o}, 32'd0);
    check("R8 step", {31'd0, step_o}, 32'd0);
    rst_ni = 1'b1;
  endtask

  initial begin
    int e;
    // phase 1: fractional rate
    delta_i = 16'h035B;
    duty_i  = DUTY_A;
    do_reset();
    find_step(20500, e);
    check("R2 first step 0x035B", e, 19712);
    @(negedge clk_i);
    check("R3 pulse width", {31'd0, step_o}, 32'd0);
    check("R7 no wrap yet", {28'd0, pwm_o}, 32'd0);

    // phase 2: step on every tick after the first
    delta_i = 16'hFFFF;
    do_reset();
    find_step(1000, e);
    check("R2 first step 0xFFFF", e, 512);
    find_step(1100, e);
    check("R1 step spacing", e, 768);

    for (int i = 0; i < NV; i++) begin
      wait_to(256 * (VSTEP[i] + 1));
      check(VREQ[i], {28'd0, pwm_o}, {28'd0, VEXP[i]});
      if (VSTEP[i] == 257) duty_i = DUTY_B;  // mid-period change must be ignored
    end

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule